// File: doc/BRIEF.md
# I2C EEPROM Sequential Read Engine

This block is the slave-side read path of a byte-addressed serial EEPROM that sits on an I2C bus. It holds the word pointer of the array. When the command decoder reports that a read has been addressed, the engine fetches the byte at the pointer from a synchronous memory port. It then shifts the byte onto SDA most significant bit first, changing the line only after SCL has gone low. Once the eighth bit has gone out, it releases SDA for the master's acknowledge, advances the pointer and prefetches the following byte while the ninth clock runs.

If the master pulls SDA low at the rising edge of the ninth clock, the prefetched byte goes out from the next SCL fall, and this continues for as long as the master keeps acknowledging. After the last location the pointer wraps to zero. A high level in the ninth bit sends the engine back to standby with SDA released. A START or STOP reported at any moment also sends it to standby. The pointer survives all of these, so the next current-address read resumes at the first byte not yet completed. A random-address read is made by loading the pointer through the load strobe, which the write path drives after its dummy write, and then issuing the read command.

Top module: `sqrd_read_engine`

## Requirements
- R1: After reset the engine does not pull SDA low (`sda_low_o` = 0), issues no memory read, and holds pointer 0, so the first read returns the byte at address 0.
- R2: A one-cycle `rd_cmd_i` pulse starts a read at the current pointer: `mem_rd_en_o` is high the next cycle, and the MSB of that byte is driven at the first SCL fall detected at least three clocks after the pulse.
- R3: Data bits go out MSB first. `sda_low_o` = 1 means the line is pulled low for a 0 bit. `sda_low_o` changes only in the cycle after an SCL fall is detected, or after an abort or read command, so it is stable while SCL is high.
- R4: The pointer advances by one when the eighth bit of a byte has been clocked out. A one-cycle `addr_load_i` pulse replaces the pointer with `addr_val_i` (random-address read). A later current-address read continues from the first byte not yet completed.
- R5: The pointer wraps to 0 after address MEM_DEPTH-1, and output continues from address 0 without a break.
- R6: SDA is released during the ninth (acknowledge) bit. The next byte's memory read is issued in the cycle after the SCL fall that ends the eighth bit, so its MSB is ready for the following SCL fall.
- R7: SDA low at the rising SCL edge of the ninth bit means acknowledge: the next byte's MSB is driven at the next SCL fall, with no limit on the number of bytes.
- R8: SDA high at the rising SCL edge of the ninth bit ends the read. The engine enters standby and keeps SDA released through any further SCL clocks until a new read command arrives.
- R9: A `start_det_i` or `stop_det_i` pulse in any state sends the engine to standby and releases SDA in the next cycle. A byte cut short is not counted, so the pointer still addresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level, as seen on the bus |
| start_det_i | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_det_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| rd_cmd_i | input | 1 | One-cycle pulse: a read of this device has been decoded and acknowledged |
| addr_load_i | input | 1 | One-cycle pulse: load the pointer from `addr_val_i` |
| addr_val_i | input | ADDR_W | New pointer value for a random-address read |
| mem_rdata_i | input | DATA_W | Memory read data, valid in the cycle after `mem_rd_en_o` |
| mem_rd_en_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Memory read address (the pointer) |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
Each SCL fall is detected at the first clock that sees SCL low, and `sda_low_o` changes one clock later. The bench therefore holds each SCL phase for eight clocks and samples SDA twice while SCL is high: once two clocks after the rise and again five clocks later, which also shows that the line held still. A byte fetch takes two clocks from a read command or from the end of a byte. The bench leaves at least three clocks after a read command before the first SCL fall, and samples the acknowledge-bit release three clocks after the ninth fall. An abort is due one clock after the START or STOP pulse, and the bench checks SDA at the very next falling clock edge. Received bytes go into a queue, and the scoreboard compares them with the expected bytes pushed by the driver, in order.

// File: rtl/sqrd_pkg.sv
package sqrd_pkg;

   // States of the read engine
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,   // standby, SDA released
      ST_ARM  = 2'd1,   // byte requested or ready, waiting for SCL fall
      ST_SEND = 2'd2,   // shifting data bits
      ST_ACK  = 2'd3    // ninth bit, SDA released, waiting for SCL rise
   } rd_state_e;

endpackage

// File: rtl/sqrd_scl_edge.sv
// Edge detector on the already-synchronised SCL level.
module sqrd_scl_edge #(
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic rise_o,
   output logic fall_o
);

   logic scl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) scl_q <= IDLE_LEVEL;
      else        scl_q <= scl_i;
   end

   assign rise_o = !scl_q && scl_i;
   assign fall_o = scl_q && !scl_i;

endmodule

// File: rtl/sqrd_addr_ptr.sv
// Word pointer with load and modular increment.
module sqrd_addr_ptr #(
   parameter int MEM_DEPTH = 16384,
   parameter int ADDR_W    = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_i,
   output logic [ADDR_W-1:0] ptr_o
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(MEM_DEPTH - 1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_inc;

   generate
      if (MEM_DEPTH < 2) begin : g_bad_depth
         $error("sqrd_addr_ptr: MEM_DEPTH must be at least 2");
      end
      if (MEM_DEPTH == (1 << ADDR_W)) begin : g_pow2_wrap
         // full binary range: overflow of the adder is the wrap
         assign ptr_inc = ptr_q + 1'b1;
      end else begin : g_cmp_wrap
         // partial range: clear after the top address
         assign ptr_inc = (ptr_q == TOP_ADDR) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr_q <= '0;
      else if (load_i) ptr_q <= load_val_i;
      else if (inc_i)  ptr_q <= ptr_inc;
   end

   assign ptr_o = ptr_q;

   // R4: a load sets the pointer to the supplied value
   a_r4_load_sets_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (ptr_q == $past(load_val_i)));

   // R4: an increment below the top address steps by one
   a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && ptr_q != TOP_ADDR) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1)));

   // R5: the top address is followed by zero
   a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && ptr_q == TOP_ADDR) |=> (ptr_q == '0));

endmodule

// File: rtl/sqrd_shifter.sv
// Output shift register with bit counter and open-drain drive flag.
module sqrd_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,      // memory data valid
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              start_i,     // drive MSB of loaded byte
   input  logic              shift_i,     // advance to next bit
   input  logic              end_i,       // byte finished, release line
   input  logic              flush_i,     // abort: release and drop data
   output logic              ready_o,
   output logic              drv_o,
   output logic              bit_o,
   output logic              last_o
);

   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              ready_q;
   logic              drv_q;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sqrd_shifter: DATA_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '1;
         cnt_q   <= '0;
         ready_q <= 1'b0;
         drv_q   <= 1'b0;
      end else if (flush_i) begin
         ready_q <= 1'b0;
         drv_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         if (start_i) begin
            cnt_q   <= '0;
            drv_q   <= 1'b1;
            ready_q <= 1'b0;
         end else if (shift_i) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b1};
            cnt_q <= cnt_q + 1'b1;
         end
         if (end_i) drv_q <= 1'b0;
         if (load_i) begin
            sh_q    <= load_data_i;
            ready_q <= 1'b1;
         end
      end
   end

   assign ready_o = ready_q;
   assign drv_o   = drv_q;
   assign bit_o   = sh_q[DATA_W-1];
   assign last_o  = (cnt_q == LAST_CNT);

   // R3: each shift advances the bit counter by exactly one
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !start_i && !flush_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)));

   // R3: a start always begins at bit position zero with the line driven
   a_r3_start_at_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !flush_i && !end_i) |=> (drv_q && cnt_q == '0));

endmodule

// File: rtl/sqrd_read_engine.sv
// Sequential read engine: pointer, prefetch, bit shifting and acknowledge.
module sqrd_read_engine
   import sqrd_pkg::*;
#(
   parameter  int MEM_DEPTH = 16384,
   parameter  int DATA_W    = 8,
   localparam int ADDR_W    = $clog2(MEM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              start_det_i,
   input  logic              stop_det_i,
   input  logic              rd_cmd_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_val_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              mem_rd_en_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic              sda_low_o
);

   generate
      if (MEM_DEPTH < 2) begin : g_bad_depth
         $error("sqrd_read_engine: MEM_DEPTH must be at least 2");
      end
   endgenerate

   rd_state_e state_q;
   logic      scl_rise, scl_fall;
   logic      abort, restart;
   logic      sh_ready, sh_drv, sh_bit, sh_last;
   logic      arm_go, bit_adv, byte_done, ack_seen, nack_seen;
   logic      fetch_q, data_vld_q;

   sqrd_scl_edge #(.IDLE_LEVEL(1'b1)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_i),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   // event decode
   assign abort     = start_det_i || stop_det_i;
   assign restart   = rd_cmd_i && !abort;
   assign arm_go    = (state_q == ST_ARM)  && scl_fall && sh_ready && !abort && !rd_cmd_i;
   assign bit_adv   = (state_q == ST_SEND) && scl_fall && !sh_last && !abort && !rd_cmd_i;
   assign byte_done = (state_q == ST_SEND) && scl_fall && sh_last && !abort && !rd_cmd_i;
   assign ack_seen  = (state_q == ST_ACK)  && scl_rise && !sda_i;
   assign nack_seen = (state_q == ST_ACK)  && scl_rise && sda_i;

   // control state
   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= ST_IDLE;
      else if (abort)   state_q <= ST_IDLE;
      else if (rd_cmd_i) state_q <= ST_ARM;
      else begin
         unique case (state_q)
            ST_IDLE: state_q <= ST_IDLE;
            ST_ARM:  if (arm_go)    state_q <= ST_SEND;
            ST_SEND: if (byte_done) state_q <= ST_ACK;
            ST_ACK: begin
               if (ack_seen)       state_q <= ST_ARM;
               else if (nack_seen) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // memory prefetch: strobe one cycle after request, data the cycle after
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_q    <= 1'b0;
         data_vld_q <= 1'b0;
      end else begin
         fetch_q    <= restart || byte_done;
         data_vld_q <= fetch_q && !abort;
      end
   end

   sqrd_addr_ptr #(.MEM_DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (addr_load_i),
      .load_val_i (addr_val_i),
      .inc_i      (byte_done),
      .ptr_o      (mem_addr_o)
   );

   sqrd_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (data_vld_q && !abort),
      .load_data_i (mem_rdata_i),
      .start_i     (arm_go),
      .shift_i     (bit_adv),
      .end_i       (byte_done),
      .flush_i     (abort || rd_cmd_i),
      .ready_o     (sh_ready),
      .drv_o       (sh_drv),
      .bit_o       (sh_bit),
      .last_o      (sh_last)
   );

   assign mem_rd_en_o = fetch_q;
   assign sda_low_o   = sh_drv && !sh_bit;

   // R3: the line only moves after an SCL fall or a control event
   a_r3_move_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_low_o) |-> $past(scl_fall || abort || rd_cmd_i));

   // R8: standby never pulls the line
   a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !sda_low_o);

   // R9: START or STOP drops to standby with SDA released
   a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (state_q == ST_IDLE && !sda_low_o));

   // R6: after the eighth bit the line is released and the next byte fetched
   a_r6_release_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (mem_rd_en_o && !sda_low_o && state_q == ST_ACK));

   // R2: a read command requests the byte at the pointer
   a_r2_cmd_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> mem_rd_en_o);

   // R7: acknowledge returns to waiting for the next SCL fall
   a_r7_ack_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_seen && !abort && !rd_cmd_i) |=> (state_q == ST_ARM));

endmodule

// File: tb/sqrd_read_engine_tb_top.sv
`timescale 1ns/1ps
module sqrd_read_engine_tb_top;

   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl = 1'b1;
   logic          mlow = 1'b0;
   logic          start_det = 1'b0;
   logic          stop_det = 1'b0;
   logic          rd_cmd = 1'b0;
   logic          addr_load = 1'b0;
   logic [AW-1:0] addr_val = '0;
   logic [7:0]    mem_rdata;
   logic          mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic          sda_low;
   logic          sda_bus;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   logic [7:0] got_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   assign sda_bus = !(sda_low || mlow);

   function automatic logic [7:0] pat(input int a);
      logic [13:0] w;
      w = a[13:0];
      return w[7:0] ^ {w[13:8], 2'b10};
   endfunction

   // synchronous memory model
   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= pat(int'(mem_addr));
   end

   sqrd_read_engine #(.MEM_DEPTH(16384), .DATA_W(8)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .start_det_i (start_det),
      .stop_det_i  (stop_det),
      .rd_cmd_i    (rd_cmd),
      .addr_load_i (addr_load),
      .addr_val_i  (addr_val),
      .mem_rdata_i (mem_rdata),
      .mem_rd_en_o (mem_rd_en),
      .mem_addr_o  (mem_addr),
      .sda_low_o   (sda_low)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         if (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(g == e, t, int'(g), int'(e));
         end
      end
   end

   task automatic load_addr(input int a);
      @(negedge clk); addr_load = 1'b1; addr_val = a[AW-1:0];
      @(negedge clk); addr_load = 1'b0;
   endtask

   task automatic start_read();
      @(negedge clk); rd_cmd = 1'b1;
      @(negedge clk); rd_cmd = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // clock one byte out of the engine and answer in the ninth bit
   task automatic read_byte(input int a, input bit ack, input string tag);
      logic [7:0] rx;
      logic       first;
      rx = '0;
      exp_q.push_back(pat(a));
      tag_q.push_back(tag);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); scl = 1'b0; mlow = 1'b0;
         repeat (8) @(negedge clk);
         scl = 1'b1;
         repeat (2) @(negedge clk);
         first = sda_bus;
         rx = {rx[6:0], sda_bus};
         repeat (5) @(negedge clk);
         chk(sda_bus == first, "R3 stable while SCL high", int'(sda_bus), int'(first));
         @(negedge clk);
      end
      @(negedge clk); scl = 1'b0;
      repeat (3) @(negedge clk);
      chk(sda_low == 1'b0, "R6 release in ninth bit", int'(sda_low), 0);
      mlow = ack;
      repeat (5) @(negedge clk);
      scl = 1'b1;
      repeat (8) @(negedge clk);
      got_q.push_back(rx);
   endtask

   // after a NACK: further clocks must see a released line, then STOP
   task automatic end_read(input int extra);
      @(negedge clk); scl = 1'b0; mlow = 1'b0;
      repeat (8) @(negedge clk);
      chk(sda_low == 1'b0, "R8 standby after NACK", int'(sda_low), 0);
      for (int i = 0; i < extra; i++) begin
         scl = 1'b1;
         repeat (4) @(negedge clk);
         chk(sda_bus == 1'b1, "R8 no drive after NACK", int'(sda_bus), 1);
         repeat (4) @(negedge clk);
         scl = 1'b0;
         repeat (8) @(negedge clk);
      end
      scl = 1'b1;
      repeat (4) @(negedge clk);
      stop_det = 1'b1;
      @(negedge clk); stop_det = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      chk(sda_low == 1'b0, "R1 SDA released", int'(sda_low), 0);
      chk(mem_rd_en == 1'b0, "R1 no fetch", int'(mem_rd_en), 0);
      chk(mem_addr == '0, "R1 pointer zero", int'(mem_addr), 0);

      // R1/R2: first current-address read returns address 0
      start_read();
      read_byte(0, 1'b0, "R2 current read at 0");
      end_read(2);

      // R7/R4: sequential read from pointer 1 with acknowledges
      start_read();
      read_byte(1, 1'b1, "R7 seq byte 1");
      read_byte(2, 1'b1, "R7 seq byte 2");
      read_byte(3, 1'b1, "R7 seq byte 3");
      read_byte(4, 1'b0, "R4 seq byte 4");
      end_read(1);

      // R4: random-address read
      load_addr(14'h1234);
      chk(mem_addr == 14'h1234, "R4 pointer load", int'(mem_addr), 'h1234);
      start_read();
      read_byte('h1234, 1'b1, "R4 random byte 0");
      read_byte('h1235, 1'b0, "R4 random byte 1");
      end_read(0);

      // R5: wrap past the top address
      load_addr(14'h3FFE);
      start_read();
      read_byte('h3FFE, 1'b1, "R5 before top");
      read_byte('h3FFF, 1'b1, "R5 top");
      read_byte(0, 1'b1, "R5 wrapped 0");
      read_byte(1, 1'b0, "R5 wrapped 1");
      end_read(0);

      // R4: current read continues after the NACKed byte
      start_read();
      read_byte(2, 1'b0, "R4 resume after NACK");
      end_read(0);

      // R9: START mid-byte aborts; unfinished byte not counted
      load_addr(14'h0100);
      start_read();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); scl = 1'b0;
         repeat (8) @(negedge clk);
         scl = 1'b1;
         repeat (8) @(negedge clk);
      end
      chk(sda_low == 1'b1, "R9 precondition bit pulled low", int'(sda_low), 1);
      start_det = 1'b1;
      @(negedge clk); start_det = 1'b0;
      chk(sda_low == 1'b0, "R9 release one cycle after START", int'(sda_low), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); scl = 1'b0;
         repeat (8) @(negedge clk);
         scl = 1'b1;
         repeat (4) @(negedge clk);
         chk(sda_bus == 1'b1, "R9 standby after abort", int'(sda_bus), 1);
         repeat (4) @(negedge clk);
      end
      chk(mem_addr == 14'h0100, "R9 pointer kept", int'(mem_addr), 'h100);
      start_read();
      read_byte('h0100, 1'b0, "R9 re-read aborted byte");
      end_read(0);

      repeat (10) @(negedge clk);
      chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule